// File: doc/BRIEF.md
# Acquisition Event Status Tracker

This block watches a sampled-data acquisition engine and keeps a 16-bit raw status word that software can poll. A conversion starts on a start strobe. It counts new-sample strobes against a programmed target and ends in one of two ways: the count reaches the target (complete), or a stop strobe arrives first (incomplete). Each event is latched into a sticky flag. A matching one-cycle pulse comes out on `evt_o` at the same bit position, so an interrupt controller outside the block can use it.

A three-state sequencer drives the conversion. `ST_IDLE` goes to `ST_CONV` on a start strobe. `ST_CONV` ends when the sample count reaches the target or when a stop strobe arrives. From there it returns to `ST_IDLE` when the transfer controller is disabled, or moves to `ST_DRAIN` when it is enabled. `ST_DRAIN` returns to `ST_IDLE` once the buffer reports empty.

A window comparator checks every new sample against a low threshold and a high threshold. A hit is not reported at once. It passes through a per-flag delay pipeline of four system clocks followed by four sample strobes. Overflow has two meanings, chosen by the transfer-controller enable:
- enabled: a sample is dropped because the buffer is still occupied;
- disabled: an unread sample is overwritten.

Top module: `acq_event_status`

## Requirements
- R1: After reset, `status_o` and `evt_o` are all zero. Bits 14 to 6 of `status_o` read zero at all times.
- R2: A start strobe in `ST_IDLE` sets the start flag (bit 2). A start strobe during `ST_CONV` is ignored: it neither sets bit 2 nor restarts the sample count.
- R3: In `ST_CONV`, the conversion completes on the new-sample strobe that brings the count to the target (target ≥ 1). A complete conversion does not set the incomplete-stop flag. A stop strobe on that same cycle is treated as completion.
- R4: A stop strobe in `ST_CONV` before the target is reached sets the incomplete-stop flag (bit 15). A stop strobe in `ST_IDLE` has no effect. `evt_o[15]` never pulses.
- R5: With the transfer controller disabled, the done flag (bit 1) is set one cycle after the conversion ends, whatever the buffer state.
- R6: With the transfer controller enabled, the done flag stays clear while the buffer is non-empty. It sets one cycle after the first cycle in `ST_DRAIN` with `buf_empty_i` high.
- R7: The data-ready bit (bit 3) equals the inverse of `buf_empty_i` one cycle earlier. A write-1-to-clear pulse on bit 3 does not affect it.
- R8: With the transfer controller enabled, a sample strobe while `buf_empty_i` is low and `buf_rd_i` is low sets the overflow flag (bit 0).
- R9: With the transfer controller disabled, a sample strobe sets the overflow flag when an earlier sample is still unread and `buf_rd_i` is low in that cycle. A sample marks data unread; `buf_rd_i` marks it read.
- R10: When window compare is enabled, a sample strictly below the low threshold arms the low flag (bit 5), and a sample strictly above the high threshold arms the high flag (bit 4). Samples equal to a threshold, and any sample taken with compare disabled, arm nothing.
- R11: An armed window flag becomes visible one cycle after the fourth sample strobe that falls at least five cycles after the detecting sample. Strobes in the four cycles right after detection do not count.
- R12: A one-cycle pulse on `clr_i[n]` clears sticky flag n (bits 15, 5, 4, 2, 1, 0). A set event in the same cycle wins over the clear.
- R13: `evt_o[n]` pulses for one cycle together with the cycle in which flag n becomes set by an event. For bit 3, it pulses when data-ready rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion start strobe |
| stop_i | input | 1 | Conversion stop strobe |
| target_i | input | CNT_W | Samples per conversion |
| sample_vld_i | input | 1 | New-sample strobe, marks one sample period |
| sample_i | input | DATA_W | Sample value |
| win_lo_i | input | DATA_W | Low window threshold |
| win_hi_i | input | DATA_W | High window threshold |
| win_en_i | input | 1 | Window compare enable |
| xfer_en_i | input | 1 | Transfer controller enabled |
| buf_empty_i | input | 1 | Data buffer is empty |
| buf_rd_i | input | 1 | Data buffer read this cycle |
| clr_i | input | 16 | Write-1-to-clear pulses, one per status bit |
| status_o | output | 16 | Raw status word |
| evt_o | output | 16 | Per-event one-cycle pulses |

## Verification
The bench builds the block with a 3-bit sample counter and 8-bit data, keeping both latencies at four. The narrow counter allows every target from 1 to 7 to be combined with every stop point from zero samples up to full count, in both transfer-controller modes. That covers each `ST_CONV` exit and the `ST_DRAIN` wait exhaustively. Directed sequences then place window detections against strobes that come back-to-back or after long gaps, to pin the exact edge where a window flag appears. They also cover both overflow meanings, clear-versus-set collisions, and ignored strobes.

// File: rtl/acq_evt_pkg.sv
package acq_evt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_DRAIN = 2'd2
    } acq_state_e;

    localparam int STAT_W  = 16;
    localparam int B_OVF   = 0;
    localparam int B_DONE  = 1;
    localparam int B_START = 2;
    localparam int B_RDY   = 3;
    localparam int B_WHI   = 4;
    localparam int B_WLO   = 5;
    localparam int B_ISTOP = 15;

    localparam logic [STAT_W-1:0] STICKY_MASK =
        (STAT_W'(1) << B_OVF) | (STAT_W'(1) << B_DONE) | (STAT_W'(1) << B_START) |
        (STAT_W'(1) << B_WHI) | (STAT_W'(1) << B_WLO) | (STAT_W'(1) << B_ISTOP);

endpackage

// File: rtl/acq_seq_fsm.sv
module acq_seq_fsm
    import acq_evt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             sample_vld_i,
    input  logic [CNT_W-1:0] target_i,
    input  logic             xfer_en_i,
    input  logic             buf_empty_i,
    output logic             start_evt_o,
    output logic             istop_evt_o,
    output logic             done_evt_o
);

    acq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             hit;
    logic             full_end;
    logic             conv_end;

    assign hit      = ({1'b0, cnt_q} + (CNT_W+1)'(1)) == {1'b0, target_i};
    assign full_end = sample_vld_i && hit;
    assign conv_end = full_end || stop_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   cnt_q <= '0;
        else if (state_q == ST_IDLE && start_i)       cnt_q <= '0;
        else if (state_q == ST_CONV && sample_vld_i)  cnt_q <= cnt_q + CNT_W'(1);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i)     state_d = ST_CONV;
            ST_CONV:  if (conv_end)    state_d = xfer_en_i ? ST_DRAIN : ST_IDLE;
            ST_DRAIN: if (buf_empty_i) state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        start_evt_o = 1'b0;
        istop_evt_o = 1'b0;
        done_evt_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:  start_evt_o = start_i;
            ST_CONV: begin
                istop_evt_o = stop_i && !full_end;
                done_evt_o  = conv_end && !xfer_en_i;
            end
            ST_DRAIN: done_evt_o = buf_empty_i;
            default: ;
        endcase
    end

    // R4: a stop seen while idle leaves the sequencer idle
    a_r4_stop_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && stop_i && !start_i) |=> (state_q == ST_IDLE));

    // R2: a start while converting does not reset the count
    a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV && !sample_vld_i && !stop_i) |=> (cnt_q == $past(cnt_q)));

    // R6: draining never finishes while the buffer holds data
    a_r6_drain_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && !buf_empty_i) |=> (state_q == ST_DRAIN));

endmodule

// File: rtl/acq_win_delay.sv
module acq_win_delay #(
    parameter int CLK_LAT = 4,
    parameter int STB_LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic det_i,
    input  logic stb_i,
    output logic fire_o
);

    logic [CLK_LAT-1:0] clk_pipe;
    logic [STB_LAT-1:0] stb_pipe;
    logic               clk_out;

    assign clk_out = clk_pipe[CLK_LAT-1];
    assign fire_o  = stb_i && stb_pipe[STB_LAT-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_pipe <= '0;
            stb_pipe <= '0;
        end else begin
            clk_pipe[0] <= det_i;
            for (int i = 1; i < CLK_LAT; i++) clk_pipe[i] <= clk_pipe[i-1];
            if (stb_i) begin
                stb_pipe[0] <= clk_out;
                for (int i = 1; i < STB_LAT; i++) stb_pipe[i] <= stb_pipe[i-1];
            end else begin
                stb_pipe[0] <= stb_pipe[0] || clk_out;
            end
        end
    end

    // R11: a pending token only enters the strobe stage from the clock stage
    a_r11_token_from_clock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stb_pipe[0]) |-> $past(clk_out));

endmodule

// File: rtl/acq_event_status.sv
module acq_event_status
    import acq_evt_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int DATA_W  = 12,
    parameter int CLK_LAT = 4,
    parameter int STB_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [CNT_W-1:0]  target_i,
    input  logic              sample_vld_i,
    input  logic [DATA_W-1:0] sample_i,
    input  logic [DATA_W-1:0] win_lo_i,
    input  logic [DATA_W-1:0] win_hi_i,
    input  logic              win_en_i,
    input  logic              xfer_en_i,
    input  logic              buf_empty_i,
    input  logic              buf_rd_i,
    input  logic [15:0]       clr_i,
    output logic [15:0]       status_o,
    output logic [15:0]       evt_o
);

    localparam int NWIN = 2;

    logic              start_evt, istop_evt, done_evt;
    logic              ovf_evt;
    logic              unread_q;
    logic              rdy_q;
    logic [NWIN-1:0]   win_det;
    logic [NWIN-1:0]   win_fire;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] flags_q;
    logic [STAT_W-1:0] evt_q;

    acq_seq_fsm #(.CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .sample_vld_i(sample_vld_i),
        .target_i    (target_i),
        .xfer_en_i   (xfer_en_i),
        .buf_empty_i (buf_empty_i),
        .start_evt_o (start_evt),
        .istop_evt_o (istop_evt),
        .done_evt_o  (done_evt)
    );

    assign win_det[0] = sample_vld_i && win_en_i && (sample_i < win_lo_i);
    assign win_det[1] = sample_vld_i && win_en_i && (sample_i > win_hi_i);

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        acq_win_delay #(.CLK_LAT(CLK_LAT), .STB_LAT(STB_LAT)) u_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .det_i (win_det[w]),
            .stb_i (sample_vld_i),
            .fire_o(win_fire[w])
        );
    end

    assign ovf_evt = sample_vld_i && !buf_rd_i &&
                     (xfer_en_i ? !buf_empty_i : unread_q);

    always_comb begin
        set_vec          = '0;
        set_vec[B_OVF]   = ovf_evt;
        set_vec[B_DONE]  = done_evt;
        set_vec[B_START] = start_evt;
        set_vec[B_WHI]   = win_fire[1];
        set_vec[B_WLO]   = win_fire[0];
        set_vec[B_ISTOP] = istop_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unread_q <= 1'b0;
            rdy_q    <= 1'b0;
            flags_q  <= '0;
            evt_q    <= '0;
        end else begin
            if (sample_vld_i)  unread_q <= 1'b1;
            else if (buf_rd_i) unread_q <= 1'b0;
            rdy_q    <= !buf_empty_i;
            flags_q  <= (flags_q & ~(clr_i & STICKY_MASK)) | set_vec;
            evt_q    <= set_vec & ~(STAT_W'(1) << B_ISTOP);
            evt_q[B_RDY] <= !buf_empty_i && !rdy_q;
        end
    end

    always_comb begin
        status_o        = flags_q & STICKY_MASK;
        status_o[B_RDY] = rdy_q;
    end
    assign evt_o = evt_q;

    // R12: sticky flags hold unless cleared
    a_r12_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[B_OVF] && !clr_i[B_OVF]) |=> status_o[B_OVF]);
    a_r12_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[B_DONE] && !clr_i[B_DONE]) |=> status_o[B_DONE]);
    a_r12_istop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[B_ISTOP] && !clr_i[B_ISTOP]) |=> status_o[B_ISTOP]);

    // R13: an event pulse always comes with its flag raised
    a_r13_done_pulse_flag: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o[B_DONE] |-> status_o[B_DONE]);

    // R11: a window flag rises only right after a sample strobe
    a_r11_wlo_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[B_WLO]) |-> $past(sample_vld_i));

    // R1: reserved bits never rise
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status_o[14:6] == '0));

endmodule

// File: tb/acq_event_status_test.sv
`timescale 1ns/1ps
module acq_event_status_test;

    localparam int CNT_W  = 3;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 0, stop_i = 0, sample_vld_i = 0;
    logic [CNT_W-1:0]  target_i = '0;
    logic [DATA_W-1:0] sample_i = '0;
    logic [DATA_W-1:0] win_lo_i = 8'd100, win_hi_i = 8'd200;
    logic              win_en_i = 0, xfer_en_i = 0, buf_empty_i = 1, buf_rd_i = 0;
    logic [15:0]       clr_i = '0;
    logic [15:0]       status_o, evt_o;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    acq_event_status #(.CNT_W(CNT_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .target_i(target_i), .sample_vld_i(sample_vld_i), .sample_i(sample_i),
        .win_lo_i(win_lo_i), .win_hi_i(win_hi_i), .win_en_i(win_en_i),
        .xfer_en_i(xfer_en_i), .buf_empty_i(buf_empty_i), .buf_rd_i(buf_rd_i),
        .clr_i(clr_i), .status_o(status_o), .evt_o(evt_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic quiet();
        start_i = 0; stop_i = 0; sample_vld_i = 0; buf_rd_i = 0; clr_i = '0;
    endtask

    task automatic clear_all();
        quiet();
        buf_empty_i = 1;
        buf_rd_i = 1;
        clr_i = 16'hFFFF;
        tick();
        quiet();
    endtask

    task automatic sample(input logic [DATA_W-1:0] d);
        sample_vld_i = 1; sample_i = d;
        tick();
        sample_vld_i = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        chk("R1 status after reset", status_o, 0);
        chk("R1 evt after reset", evt_o, 0);
        rst_n = 1;
        tick();
        chk("R1 status idle", status_o, 0);

        // exhaustive sweep over mode, target and stop point (R3 R4 R5 R6)
        for (int m = 0; m < 2; m++) begin
            for (int t = 1; t < 8; t++) begin
                for (int k = 0; k <= t; k++) begin
                    xfer_en_i = m[0]; win_en_i = 1; target_i = CNT_W'(t);
                    clear_all();
                    start_i = 1; tick(); start_i = 0;
                    chk("R2 start flag", status_o[2], 1);
                    chk("R13 start pulse", evt_o[2], 1);
                    for (int i = 0; i < k; i++) begin
                        buf_empty_i = 1; buf_rd_i = 1;
                        sample(8'd150);
                        buf_rd_i = 0;
                        if (i < t - 1)
                            chk("R3 no early done", status_o[1], 0);
                    end
                    if (k < t) begin
                        stop_i = 1; tick(); stop_i = 0;
                        chk("R4 incomplete stop", status_o[15], 1);
                        chk("R4 no stop pulse", evt_o[15], 0);
                    end else begin
                        chk("R3 full count no istop", status_o[15], 0);
                    end
                    if (m == 0) begin
                        chk("R5 done immediate", status_o[1], 1);
                        chk("R13 done pulse", evt_o[1], 1);
                    end else begin
                        chk("R6 done waits", status_o[1], 0);
                        buf_empty_i = 0; tick(); tick();
                        chk("R6 done while nonempty", status_o[1], 0);
                        chk("R7 ready high", status_o[3], 1);
                        buf_empty_i = 1; tick();
                        chk("R6 done after empty", status_o[1], 1);
                        chk("R13 done pulse drain", evt_o[1], 1);
                    end
                    chk("R10 in-window no flags", {30'd0, status_o[5:4]}, 0);
                    tick();
                    chk("R13 pulse one cycle", evt_o[1], 0);
                end
            end
        end

        // R4 stop while idle
        xfer_en_i = 0; clear_all();
        stop_i = 1; tick(); stop_i = 0; tick();
        chk("R4 idle stop ignored", status_o, 0);

        // R2 start during conversion ignored, count not restarted
        target_i = 3'd3; clear_all();
        start_i = 1; tick(); start_i = 0;
        clr_i[2] = 1; tick(); clr_i = '0;
        chk("R12 start cleared", status_o[2], 0);
        buf_rd_i = 1; sample(8'd150);
        start_i = 1; tick(); start_i = 0;
        chk("R2 start ignored in conv", status_o[2], 0);
        sample(8'd150); sample(8'd150);
        chk("R2 count kept done", status_o[1], 1);
        buf_rd_i = 0;

        // R12 set wins over clear
        clear_all();
        start_i = 1; clr_i[2] = 1; tick(); quiet();
        chk("R12 set wins", status_o[2], 1);
        stop_i = 1; tick(); quiet();
        clr_i = 16'h8003; tick(); quiet();
        chk("R12 clear istop", status_o[15], 0);
        chk("R12 clear done", status_o[1], 0);

        // R7 data-ready not clearable
        buf_empty_i = 0; tick();
        chk("R7 ready", status_o[3], 1);
        chk("R13 ready pulse", evt_o[3], 1);
        clr_i[3] = 1; tick(); clr_i = '0;
        chk("R7 ready not cleared", status_o[3], 1);
        buf_empty_i = 1; tick();
        chk("R7 ready drops", status_o[3], 0);

        // R9 overflow, transfer disabled
        xfer_en_i = 0; clear_all();
        buf_empty_i = 0;
        sample(8'd150);
        chk("R9 first sample no ovf", status_o[0], 0);
        buf_rd_i = 1; sample(8'd150); buf_rd_i = 0;
        chk("R9 read same cycle no ovf", status_o[0], 0);
        sample(8'd150);
        chk("R9 overwrite sets ovf", status_o[0], 1);
        chk("R13 ovf pulse", evt_o[0], 1);

        // R8 overflow, transfer enabled
        xfer_en_i = 1; clear_all();
        buf_empty_i = 1; sample(8'd150); sample(8'd150);
        chk("R8 empty buffer no ovf", status_o[0], 0);
        buf_empty_i = 0; sample(8'd150);
        chk("R8 drop sets ovf", status_o[0], 1);
        buf_empty_i = 1; xfer_en_i = 0;

        // R10 R11 window low, back-to-back strobes
        clear_all(); win_en_i = 1;
        sample(8'd50);
        for (int j = 1; j <= 8; j++) begin
            sample(8'd150);
            if (j == 7) chk("R11 low not yet", status_o[5], 0);
        end
        chk("R11 low after latency", status_o[5], 1);
        chk("R13 low pulse", evt_o[5], 1);

        // R11 window high with a gap before strobes
        clear_all();
        sample(8'd250);
        repeat (10) tick();
        sample(8'd150); sample(8'd150); sample(8'd150);
        chk("R11 high not yet", status_o[4], 0);
        sample(8'd150);
        chk("R11 high after 4 strobes", status_o[4], 1);

        // R10 equal threshold and disabled compare
        clear_all();
        sample(8'd100); sample(8'd200);
        win_en_i = 0; sample(8'd10); sample(8'd255);
        repeat (12) sample(8'd150);
        chk("R10 no window flags", {30'd0, status_o[5:4]}, 0);
        chk("R1 reserved zero", {23'd0, status_o[14:6]}, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule